// File: doc/BRIEF.md
# PLL Lock Status Qualifier

This block decides, for each of several PLLs, when the PLL's raw lock indication can be trusted. It turns that decision into sticky lock and unlock events that software can poll or take as an interrupt. Each PLL has an enable input and a raw lock input. The raw lock is brought into the block clock domain through a two-flop synchronizer. A per-PLL start-up counter advances on a slow-clock tick strobe.

A start-up delay, shared by all PLLs, sets how many slow ticks must pass after a PLL is enabled before its lock is examined. When lock detection is switched off for a PLL, the expiry of that window alone serves as the ready indication. Unlock detection is enabled separately for each PLL. It reports a loss of lock that follows a lock seen inside the qualified window.

Software reaches the block through a simple register bus. The bus has a write strobe, a read strobe, a 3-bit word address and a combinational read data port. Addresses: 0 start-up delay, 1 lock-detect enables, 2 unlock-detect enables, 3 event flags, 4 mask set, 5 mask clear, 6 mask readback, 7 live state. Registers 3 to 7 place PLL i in bit i (lock side) and bit 16+i (unlock or done side).

Top module: `pll_lock_qual`

## Requirements
- R1: For each PLL, the start-up counter is held at zero while the PLL enable is low, and it restarts from zero on the enable's rising edge. It then advances once per slow tick. The done bit (address 7, bit 16+i) reads 1 once the count equals a nonzero delay. It never reads 1 while the delay is zero or the PLL is disabled.
- R2: With lock detection on (address 1, bit i) and a nonzero delay, the ready bit (address 7, bit i) stays 0 until done is set. After that it follows the synchronized raw lock.
- R3: With lock detection on and a zero delay, the ready bit follows the synchronized raw lock while the PLL is enabled. The raw lock reaches it through a two-flop synchronizer.
- R4: With lock detection off and a nonzero delay, the ready bit equals the done bit, whatever the raw lock is.
- R5: With lock detection off and a zero delay, the ready bit stays 0 and no lock event is raised.
- R6: A lock flag (address 3, bit i) is set on each rising edge of ready. An unlock flag (address 3, bit 16+i) is set only under four conditions together: unlock detection is on (address 2, bit i), the window has elapsed, the synchronized lock was seen high inside the window since the enable, and that lock then falls.
- R7: Writes to the start-up delay (address 0) are ignored while any PLL enable is high.
- R8: Flags are sticky. A read of address 3 returns them and then clears them. An event in the same cycle as the read stays set.
- R9: Writing 1s to address 4 sets mask bits, and writing 1s to address 5 clears them. Address 6 reads the mask back in the same layout as the flags.
- R10: The interrupt output is high exactly when some flag and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period |
| pll_en | input | NPLL | Enable of each PLL |
| raw_lock | input | NPLL | Unsynchronized lock output of each PLL |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps the delay from 0 to 4 against both settings of lock detection and both levels of raw lock. It samples ready and done one tick before the window closes and again at its close. A counter that is off by one, or that lets the raw lock through early, shows up at the earlier sample. A design that treats an unqualified PLL as locked shows up in the zero-delay, detection-off corner. Other directed steps cover several further faults:
- A loss of lock with no prior qualified lock; a design that reports unlock on any low level would flag it.
- A disable in mid-count; a counter that does not restart reaches done early.
- A delay write while an unrelated PLL is enabled; a design that checks only one enable would accept it.
- The mask set and clear pair; an interrupt that ignores the mask stays high after the clear.

// File: rtl/pll_lock_qual.sv
module pll_lock_qual #(
  parameter int NPLL = 2,
  parameter int DLYW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slow_tick,
  input  logic [NPLL-1:0] pll_en,
  input  logic [NPLL-1:0] raw_lock,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [2:0]      addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            irq
);
  localparam int HI = 16;

  logic [DLYW-1:0] dly_r;
  logic [NPLL-1:0] lken_r, ulen_r;
  logic [NPLL-1:0] lk_flg, ul_flg, lk_msk, ul_msk;
  logic [NPLL-1:0] s1, s2, en_q, rdy_q, got_lk;
  logic [NPLL-1:0] done, win, rdy, lk_evt, ul_evt;
  logic [DLYW-1:0] cnt [NPLL];

  wire st_rd  = rd_en && addr == 3'd3;
  wire dly_nz = dly_r != '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dly_r  <= '0;
      lken_r <= '0;
      ulen_r <= '0;
      lk_msk <= '0;
      ul_msk <= '0;
    end else if (wr_en) begin
      case (addr)
        3'd0: if (pll_en == '0) dly_r <= wdata[DLYW-1:0];
        3'd1: lken_r <= wdata[NPLL-1:0];
        3'd2: ulen_r <= wdata[NPLL-1:0];
        3'd4: begin
          lk_msk <= lk_msk | wdata[NPLL-1:0];
          ul_msk <= ul_msk | wdata[HI +: NPLL];
        end
        3'd5: begin
          lk_msk <= lk_msk & ~wdata[NPLL-1:0];
          ul_msk <= ul_msk & ~wdata[HI +: NPLL];
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1     <= '0;
      s2     <= '0;
      en_q   <= '0;
      rdy_q  <= '0;
      lk_flg <= '0;
      ul_flg <= '0;
    end else begin
      s1     <= raw_lock;
      s2     <= s1;
      en_q   <= pll_en;
      rdy_q  <= rdy;
      lk_flg <= (lk_flg & ~{NPLL{st_rd}}) | lk_evt;
      ul_flg <= (ul_flg & ~{NPLL{st_rd}}) | ul_evt;
    end

  for (genvar i = 0; i < NPLL; i++) begin : g_pll
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                        cnt[i] <= '0;
      else if (!(pll_en[i] && en_q[i]))  cnt[i] <= '0;
      else if (slow_tick && cnt[i] != dly_r) cnt[i] <= cnt[i] + 1'b1;

    assign done[i]   = pll_en[i] && dly_nz && cnt[i] == dly_r;
    assign win[i]    = !dly_nz || done[i];
    assign rdy[i]    = pll_en[i] && (lken_r[i] ? (win[i] && s2[i]) : done[i]);
    assign lk_evt[i] = rdy[i] && !rdy_q[i];
    assign ul_evt[i] = pll_en[i] && ulen_r[i] && win[i] && got_lk[i] && !s2[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                   got_lk[i] <= 1'b0;
      else if (!pll_en[i] || ul_evt[i])             got_lk[i] <= 1'b0;
      else if (ulen_r[i] && win[i] && s2[i])        got_lk[i] <= 1'b1;

    a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_nz && pll_en[i]) |-> cnt[i] <= dly_r);
    a_r5_no_source_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (!lken_r[i] && !dly_nz) |-> !rdy[i]);
    a_r6_lock_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lk_flg[i]) |-> $past(rdy[i]));
    a_r6_unlock_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ul_flg[i]) |-> $past(got_lk[i]));
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_flg[i] && !st_rd) |=> lk_flg[i]);
  end

  a_r7_dly_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_en != '0) |=> $stable(dly_r));

  assign irq = |{lk_flg & lk_msk, ul_flg & ul_msk};

  a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_msk == '0 && ul_msk == '0) |-> !irq);

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: rdata[DLYW-1:0] = dly_r;
      3'd1: rdata[NPLL-1:0] = lken_r;
      3'd2: rdata[NPLL-1:0] = ulen_r;
      3'd3: begin rdata[NPLL-1:0] = lk_flg; rdata[HI +: NPLL] = ul_flg; end
      3'd6: begin rdata[NPLL-1:0] = lk_msk; rdata[HI +: NPLL] = ul_msk; end
      3'd7: begin rdata[NPLL-1:0] = rdy;    rdata[HI +: NPLL] = done;   end
      default: ;
    endcase
  end
endmodule

// File: tb/pll_lock_qual_tb.sv
module pll_lock_qual_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPLL = 2;

  logic clk = 0, rst_n = 0, slow_tick = 0, wr_en = 0, rd_en = 0;
  logic [NPLL-1:0] pll_en = '0, raw_lock = '0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata, rv;
  logic irq;
  int ncmp = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_lock_qual #(.NPLL(NPLL), .DLYW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .pll_en(pll_en),
    .raw_lock(raw_lock), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); slow_tick = 1;
      @(negedge clk); slow_tick = 0;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1;
    wait_clk(1);
    bus_rd(3'd3, rv); check("R8 reset flags", rv, 0);
    bus_rd(3'd7, rv); check("R1 reset live state", rv, 0);
    check("R10 reset irq", {31'd0, irq}, 0);

    for (int d = 0; d <= 4; d++)
      for (int lk = 0; lk <= 1; lk++)
        for (int raw = 0; raw <= 1; raw++) begin
          logic expr;
          pll_en = '0;
          raw_lock = raw[NPLL-1:0];
          bus_wr(3'd0, d);
          bus_wr(3'd1, lk);
          wait_clk(3);
          bus_rd(3'd3, rv);
          @(negedge clk); pll_en[0] = 1;
          wait_clk(2);
          if (d > 0) begin
            ticks(d - 1);
            bus_rd(3'd7, rv);
            check("R2/R4 before window closes", rv, 0);
            ticks(1);
            expr = lk ? raw[0] : 1'b1;
            bus_rd(3'd7, rv);
            check(lk ? "R2 ready after window" : "R4 ready equals done",
                  rv, {15'd0, 1'b1, 15'd0, expr});
          end else begin
            expr = lk ? raw[0] : 1'b0;
            bus_rd(3'd7, rv);
            check(lk ? "R3 zero delay ready" : "R5 no source ready", rv, {31'd0, expr});
          end
          wait_clk(2);
          bus_rd(3'd3, rv);
          check("R6 lock flag on ready rise", rv, {31'd0, expr});
          bus_rd(3'd3, rv);
          check("R8 flags cleared by read", rv, 0);
        end

    pll_en = '0;
    bus_wr(3'd0, 3); bus_wr(3'd1, 0);
    @(negedge clk); pll_en[0] = 1;
    wait_clk(2);
    ticks(2);
    @(negedge clk); pll_en[0] = 0;
    @(negedge clk); pll_en[0] = 1;
    wait_clk(2);
    ticks(2);
    bus_rd(3'd7, rv); check("R1 restart after re-enable", rv, 0);
    ticks(1);
    bus_rd(3'd7, rv); check("R1 done after full count", rv, 32'h0001_0001);

    pll_en = 2'b10;
    bus_wr(3'd0, 7);
    bus_rd(3'd0, rv); check("R7 delay write ignored", rv, 3);
    pll_en = '0;
    bus_wr(3'd0, 7);
    bus_rd(3'd0, rv); check("R7 delay write accepted", rv, 7);

    bus_wr(3'd0, 2); bus_wr(3'd1, 1); bus_wr(3'd2, 1);
    raw_lock = 0;
    wait_clk(3);
    bus_rd(3'd3, rv);
    @(negedge clk); pll_en[0] = 1;
    wait_clk(2);
    raw_lock[0] = 1; wait_clk(4);
    raw_lock[0] = 0; wait_clk(4);
    ticks(2);
    wait_clk(3);
    bus_rd(3'd3, rv); check("R6 no unlock without qualified lock", rv, 0);
    bus_wr(3'd4, 1);
    bus_rd(3'd6, rv); check("R9 mask readback", rv, 1);
    raw_lock[0] = 1; wait_clk(4);
    check("R10 irq on masked lock flag", {31'd0, irq}, 1);
    bus_wr(3'd5, 1);
    check("R10 irq low after mask clear", {31'd0, irq}, 0);
    bus_wr(3'd4, 32'h0001_0000);
    raw_lock[0] = 0; wait_clk(4);
    check("R10 irq on masked unlock flag", {31'd0, irq}, 1);
    bus_rd(3'd6, rv); check("R9 mask readback unlock", rv, 32'h0001_0000);
    bus_rd(3'd3, rv); check("R6 lock then unlock flags", rv, 32'h0001_0001);
    bus_rd(3'd3, rv); check("R8 cleared after read", rv, 0);
    check("R10 irq low after clear", {31'd0, irq}, 0);

    summary();
    $finish;
  end
endmodule